// File: doc/BRIEF.md
# Three-Channel Digital Black-Level Clamp

This block removes the black-level error from three digitized video channels (A, B and C) that share one pixel clock and one line timing. On every line, a timing input marks the back porch. While it is high, the block collects the first sixteen samples of each channel and averages them. When the porch ends, each channel's loop moves its correction offset a quarter of the way toward the measured level. The offset is then subtracted from every pixel, so black inputs settle at code 0.

Each channel runs its own loop. A single freeze input stops all three loops from updating, and the offsets held at that time stay in use. Each channel also has a manual enable and a 12-bit two's-complement manual offset. When the enable is set, the manual value replaces the loop offset on the output. The loop keeps tracking in the background. Results are clipped to the 12-bit range.

Top module: `video_fine_clamp`

## Requirements
- R1: While reset is low, all outputs are 0. After reset, every loop offset is 0, so with no porch activity each output equals its input delayed by one cycle.
- R2: Each output is registered: the value after clock edge k is clip(in - eff_offset, 0, 4095), using the input and the effective offset in force before edge k.
- R3: While `porch` is high, only the first 16 samples of each channel are summed. Any further samples in the same porch are ignored. The measured level is floor(sum/16).
- R4: On the first edge where `porch` is low after samples were taken, each loop offset becomes off + floor((level - off)/4), using an arithmetic shift. The new offset first affects the output registered on the following edge.
- R5: A porch with fewer than 16 samples, or no porch at all, leaves every loop offset unchanged.
- R6: The three channels are measured and corrected independently of one another.
- R7: If `freeze` is high on the edge that closes a porch, none of the three loop offsets change, and the held offsets continue to be applied.
- R8: When `man_x_en` is high, the output of channel x uses `man_x_val` (12-bit two's complement, -2048 to 2047) as its offset in place of the loop offset. The loop itself still updates.
- R9: The corrected output saturates at 0 when in - offset is negative and at 4095 when in - offset exceeds 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| porch | input | 1 | High during the back-porch measurement window |
| freeze | input | 1 | Blocks offset updates on all three loops |
| in_a | input | 12 | Channel A pixel, unsigned |
| in_b | input | 12 | Channel B pixel, unsigned |
| in_c | input | 12 | Channel C pixel, unsigned |
| man_a_en | input | 1 | Channel A manual offset select |
| man_a_val | input | 12 | Channel A manual offset, two's complement |
| man_b_en | input | 1 | Channel B manual offset select |
| man_b_val | input | 12 | Channel B manual offset, two's complement |
| man_c_en | input | 1 | Channel C manual offset select |
| man_c_val | input | 12 | Channel C manual offset, two's complement |
| out_a | output | 12 | Channel A corrected pixel |
| out_b | output | 12 | Channel B corrected pixel |
| out_c | output | 12 | Channel C corrected pixel |

## Verification
A wrong loop offset shows up at the ports on the second edge after a porch closes: every active pixel of that channel shifts by the error, and the shift stays until a later porch corrects it. A sample counter that miscounts a short or overlong porch changes the average, so it also appears on the next line's pixels. A freeze or manual path that leaks shows as an output differing from the held or programmed offset on the first pixel after the porch. Because every pixel is compared against an independently computed loop, any such fault is caught within one line.

// File: rtl/video_fine_clamp.sv
module video_fine_clamp #(
  parameter int DW         = 12,
  parameter int AVG_LOG    = 4,
  parameter int GAIN_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          porch,
  input  logic          freeze,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  input  logic          man_a_en,
  input  logic [DW-1:0] man_a_val,
  input  logic          man_b_en,
  input  logic [DW-1:0] man_b_val,
  input  logic          man_c_en,
  input  logic [DW-1:0] man_c_val,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic [DW-1:0] out_c
);
  localparam int NS   = 1 << AVG_LOG;
  localparam int OW   = DW + 1;
  localparam int SW   = DW + AVG_LOG;
  localparam int CW   = AVG_LOG + 1;
  localparam int NCH  = 3;
  localparam logic signed [OW:0] TOP = (OW+1)'((1 << DW) - 1);

  logic [CW-1:0] cnt;
  logic          take, fin, full;
  logic [DW-1:0] din     [NCH];
  logic [DW-1:0] dout    [NCH];
  logic          man_en  [NCH];
  logic [DW-1:0] man_val [NCH];
  logic [NCH*OW-1:0] off_flat;

  assign take = porch && (cnt < CW'(NS));
  assign fin  = !porch && (cnt != '0);
  assign full = (cnt == CW'(NS));

  assign din[0] = in_a;   assign din[1] = in_b;   assign din[2] = in_c;
  assign man_en[0] = man_a_en;  assign man_en[1] = man_b_en;  assign man_en[2] = man_c_en;
  assign man_val[0] = man_a_val; assign man_val[1] = man_b_val; assign man_val[2] = man_c_val;
  assign out_a = dout[0]; assign out_b = dout[1]; assign out_c = dout[2];

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (take) cnt <= cnt + 1'b1;
    else if (fin)  cnt <= '0;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [SW-1:0]        sum;
    logic signed [OW-1:0] off;
    logic signed [OW-1:0] eff;
    logic signed [OW:0]   err, nxt, diff;

    assign err  = $signed({2'b00, sum[SW-1:AVG_LOG]}) - $signed({off[OW-1], off});
    assign nxt  = $signed({off[OW-1], off}) + (err >>> GAIN_SHIFT);
    assign eff  = man_en[ch] ? $signed({man_val[ch][DW-1], man_val[ch]}) : off;
    assign diff = $signed({2'b00, din[ch]}) - $signed({eff[OW-1], eff});
    assign off_flat[ch*OW +: OW] = off;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sum <= '0;
        off <= '0;
      end else if (take) begin
        sum <= sum + SW'(din[ch]);
      end else if (fin) begin
        sum <= '0;
        if (full && !freeze) off <= nxt[OW-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)              dout[ch] <= '0;
      else if (diff < 0)       dout[ch] <= '0;
      else if (diff > TOP)     dout[ch] <= TOP[DW-1:0];
      else                     dout[ch] <= diff[DW-1:0];
    end
  end
endmodule

// File: rtl/video_fine_clamp_chk.sv
module video_fine_clamp_chk #(
  parameter int DW      = 12,
  parameter int OW      = 13,
  parameter int AVG_LOG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            porch,
  input logic            freeze,
  input logic [AVG_LOG:0] cnt,
  input logic [3*OW-1:0] off_flat,
  input logic            man_a_en,
  input logic [DW-1:0]   man_a_val,
  input logic [DW-1:0]   in_a,
  input logic [DW-1:0]   out_a
);
  localparam int NS = 1 << AVG_LOG;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AVG_LOG+1)'(NS));

  p_hold_in_porch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    porch |=> $stable(off_flat));

  p_short_porch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!porch && cnt != (AVG_LOG+1)'(NS)) |=> $stable(off_flat));

  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(off_flat));

  p_manual_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (man_a_en && man_a_val == '0) |=> (out_a == $past(in_a)));

  p_loop_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !off_flat[OW-1] && !off_flat[2*OW-1] && !off_flat[3*OW-1]);
endmodule

bind video_fine_clamp video_fine_clamp_chk #(.DW(DW), .OW(OW), .AVG_LOG(AVG_LOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .porch(porch), .freeze(freeze), .cnt(cnt),
  .off_flat(off_flat), .man_a_en(man_a_en), .man_a_val(man_a_val),
  .in_a(in_a), .out_a(out_a)
);

// File: tb/sim_video_fine_clamp.sv
module sim_video_fine_clamp;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, porch = 0, freeze = 0;
  logic [11:0] in_a = 0, in_b = 0, in_c = 0;
  logic man_a_en = 0, man_b_en = 0, man_c_en = 0;
  logic [11:0] man_a_val = 0, man_b_val = 0, man_c_val = 0;
  logic [11:0] out_a, out_b, out_c;

  int checks = 0, errors = 0;
  string tag = "R1";
  int moff[3], msum[3], mcnt = 0, expv[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  video_fine_clamp u0 (.*);

  function automatic int clip(int v);
    return v < 0 ? 0 : (v > 4095 ? 4095 : v);
  endfunction

  function automatic int sx12(logic [11:0] v);
    return v[11] ? int'(v) - 4096 : int'(v);
  endfunction

  task automatic model_edge();
    int ins[3]; int ens[3]; int mv[3];
    ins = '{int'(in_a), int'(in_b), int'(in_c)};
    ens = '{int'(man_a_en), int'(man_b_en), int'(man_c_en)};
    mv  = '{sx12(man_a_val), sx12(man_b_val), sx12(man_c_val)};
    for (int ch = 0; ch < 3; ch++)
      expv[ch] = clip(ins[ch] - (ens[ch] ? mv[ch] : moff[ch]));
    if (porch && mcnt < 16) begin
      for (int ch = 0; ch < 3; ch++) msum[ch] += ins[ch];
      mcnt++;
    end else if (!porch && mcnt != 0) begin
      for (int ch = 0; ch < 3; ch++) begin
        if (mcnt == 16 && !freeze) moff[ch] += ((msum[ch] >>> 4) - moff[ch]) >>> 2;
        msum[ch] = 0;
      end
      mcnt = 0;
    end
  endtask

  task automatic chk(string t, int act, int exp_v, string nm);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, nm, act, exp_v, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, int'(out_a), expv[0], "out_a");
    chk(tag, int'(out_b), expv[1], "out_b");
    chk(tag, int'(out_c), expv[2], "out_c");
  endtask

  task automatic line(int plen, int la, int lb, int lc, int act);
    porch = 1;
    for (int i = 0; i < plen; i++) begin
      in_a = 12'(la + i % 3); in_b = 12'(lb + i % 2); in_c = 12'(lc);
      cyc();
    end
    porch = 0;
    for (int i = 0; i < act; i++) begin
      in_a = 12'($urandom_range(4095)); in_b = 12'($urandom_range(4095));
      in_c = 12'($urandom_range(4095));
      cyc();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(20240611));
    for (int ch = 0; ch < 3; ch++) begin moff[ch] = 0; msum[ch] = 0; end
    // R1: outputs held at zero during reset
    in_a = 12'd77; in_b = 12'd88; in_c = 12'd99;
    repeat (3) begin
      @(negedge clk);
      chk("R1", int'(out_a), 0, "out_a");
      chk("R1", int'(out_b), 0, "out_b");
      chk("R1", int'(out_c), 0, "out_c");
    end
    rst_n = 1;
    // R1: offsets start at zero
    tag = "R1"; in_a = 12'd100; in_b = 12'd200; in_c = 12'd300;
    repeat (3) cyc();
    // R3 R4: full porch, then overlong porch with large tail samples
    tag = "R4"; line(16, 400, 80, 0, 6);
    tag = "R3"; porch = 1;
    for (int i = 0; i < 20; i++) begin
      in_a = (i < 16) ? 12'd400 : 12'd4000; in_b = 12'd80; in_c = 12'd0;
      cyc();
    end
    porch = 0; in_a = 12'd500; repeat (4) cyc();
    // R5: short porch and absent porch
    tag = "R5"; line(10, 3000, 3000, 3000, 8);
    line(0, 0, 0, 0, 8);
    line(15, 2000, 2000, 2000, 8);
    // R6: distinct levels per channel converge separately
    tag = "R6";
    for (int k = 0; k < 12; k++) line(16, 256, 1024, 32, 10);
    // R7: frozen loops keep offsets
    tag = "R7"; freeze = 1;
    for (int k = 0; k < 4; k++) line(16, 3500, 10, 2000, 10);
    freeze = 0; line(16, 3500, 10, 2000, 10);
    // R8: manual overrides per channel, loop still tracks
    tag = "R8"; man_a_en = 1; man_a_val = 12'd0; man_b_en = 1; man_b_val = 12'd50;
    man_c_en = 1; man_c_val = 12'hF9C;
    for (int k = 0; k < 3; k++) line(16, 600, 600, 600, 10);
    man_a_en = 0; man_b_en = 0; man_c_en = 0; line(0, 0, 0, 0, 6);
    // R9: saturation at both ends
    tag = "R9"; man_a_en = 1; man_a_val = 12'h800; man_b_en = 1; man_b_val = 12'h7FF;
    in_a = 12'd3000; in_b = 12'd100; in_c = 12'd0; repeat (3) cyc();
    in_a = 12'd4095; in_b = 12'd2047; repeat (2) cyc();
    man_a_en = 0; man_b_en = 0;
    // R2: random lines with random controls
    tag = "R2";
    for (int k = 0; k < 300; k++) begin
      freeze   = ($urandom_range(7) == 0);
      man_a_en = ($urandom_range(5) == 0); man_a_val = 12'($urandom);
      man_b_en = ($urandom_range(5) == 0); man_b_val = 12'($urandom);
      man_c_en = ($urandom_range(5) == 0); man_c_val = 12'($urandom);
      line($urandom_range(24), $urandom_range(4000), $urandom_range(4000),
           $urandom_range(4000), $urandom_range(40) + 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule